// File: doc/BRIEF.md
# Low-Side Soft Engagement for Start-Up into a Charged Output

When a buck stage starts while its output already holds a voltage, turning the low-side switch on at full width at once would pull current back out of the output and pull the voltage down. This block sits between the regulator's normal complementary low-side drive and the low-side gate. It holds the low-side switch off until the high-side switch has fired once. Until then the stage runs in diode mode. After that first pulse it lets the low-side switch conduct for only a fraction of its nominal on-time. The fraction grows in quarter steps until the full width is reached.

After each high-side pulse ends, a conduction window opens. Its length is the current quarter fraction of a nominal on-time, given in clock cycles. The low-side gate is the AND of this window and the incoming drive. A 2-bit setting selects how many pulses are spent at each step. When the last full-width pulse is complete, the block raises a done flag at the next high-side pulse. From then on it passes the drive through unchanged. Dropping the start request returns it to the off state, and the next start begins the sequence again.

Top module: `lowside_prebias_ramp`

## Requirements
- R1: After `start_req` rises, `ls_gate` stays low, whatever `ls_drive_in` does, until `hs_gate` has been sampled high and then sampled low again.
- R2: Each ramp window opens in the cycle after the clock edge at which `hs_gate` is first sampled low. It stays open for floor(k*`nom_on_cycles`/4) cycles, where k is the step number (1 to 4). A window of zero cycles produces no pulse.
- R3: The steps run in order: one quarter, one half, three quarters, then the full nominal width. No step is skipped or repeated.
- R4: The number of pulses per step is 32 when `pps_sel`=00, 16 when 01, and 8 when 10 or 11.
- R5: While ramping, `ls_gate` is low whenever `hs_gate` is high. A rising `hs_gate` closes an open window at once.
- R6: `ls_gate` is never high unless `ls_drive_in` is high. Inside a window, the gate follows the drive.
- R7: `ramp_done` rises in the cycle after the first clock edge at which `hs_gate` is sampled high following the last full-width window. It then stays high while `start_req` is high, and `ls_gate` equals `ls_drive_in`.
- R8: While `start_req` is low, `ls_gate` is low. One cycle later `ramp_done` is low. The next start repeats R1 and begins again at the one-quarter step.
- R9: After synchronous reset, `ls_gate` and `ramp_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Start request; low holds the block in the off state |
| hs_gate | input | 1 | High-side gate pulse for the current cycle |
| ls_drive_in | input | 1 | Normal complementary low-side drive |
| nom_on_cycles | input | NOM_W | Nominal low-side on-time in clock cycles |
| pps_sel | input | 2 | Pulses per step: 00=32, 01=16, 10/11=8 |
| ls_gate | output | 1 | Gated low-side drive |
| ramp_done | output | 1 | Ramp complete; drive passed through |

## Verification
Full ramps run at all four pulse-count settings, with nominal widths of 20, 13, 8 and 4 cycles. Each pulse is measured, so an error in the quarter scaling (including floor rounding at 13), the step order or the per-step count shows up as a wrong width on a specific pulse. A long idle drive before the first high-side pulse separates the diode-mode hold from the windowing. A short drive and an early high-side rise show which of the two ends a window. Aborting mid-ramp and restarting checks that the sequence begins again at one quarter. Passing a wide drive after completion shows that the gate is no longer limited.

// File: rtl/lowside_prebias_ramp_pkg.sv
package lowside_prebias_ramp_pkg;

    // Widest nominal on-time the scaling function supports.
    localparam int NOM_MAX_W = 16;
    // Counter width able to hold the largest pulses-per-step value (32).
    localparam int PPS_W     = 6;
    localparam int STEP_W    = 2;

    typedef enum logic [1:0] {
        PH_IDLE,   // start not requested
        PH_WAIT,   // diode mode, waiting for the first high-side pulse
        PH_RAMP,   // windowed low-side conduction
        PH_DONE    // drive passed through
    } phase_t;

    // Quarter multiple of the nominal width, built from shifts and adds.
    // The step index is 0..3 and maps to 1/4, 2/4, 3/4 and 4/4.
    function automatic logic [NOM_MAX_W-1:0] quarter_scale(
        input logic [NOM_MAX_W-1:0] nom,
        input logic [STEP_W-1:0]    step
    );
        logic [NOM_MAX_W+1:0] ext;
        logic [NOM_MAX_W+1:0] res;
        ext = {2'b00, nom};
        case (step)
            2'd0:    res = ext >> 2;
            2'd1:    res = ext >> 1;
            2'd2:    res = (ext + (ext << 1)) >> 2;
            default: res = ext;
        endcase
        return res[NOM_MAX_W-1:0];
    endfunction

    // Pulses spent at each step, from the 2-bit selector.
    function automatic logic [PPS_W-1:0] steps_pulses(input logic [1:0] sel);
        case (sel)
            2'b00:   return PPS_W'(32);
            2'b01:   return PPS_W'(16);
            default: return PPS_W'(8);
        endcase
    endfunction

endpackage

// File: rtl/lowside_prebias_hs_edge.sv
module lowside_prebias_hs_edge (
    input  logic clk,
    input  logic rst,
    input  logic hs_gate,
    output logic hs_fall
);
    logic hs_q;

    always_ff @(posedge clk) begin
        if (rst) hs_q <= 1'b0;
        else     hs_q <= hs_gate;
    end

    assign hs_fall = hs_q & ~hs_gate;
endmodule

// File: rtl/lowside_prebias_sequencer.sv
module lowside_prebias_sequencer
    import lowside_prebias_ramp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_req,
    input  logic              hs_gate,
    input  logic              hs_fall,
    input  logic [1:0]        pps_sel,
    output phase_t            phase,
    output logic [STEP_W-1:0] step,
    output logic              load_win
);
    localparam logic [STEP_W-1:0] LAST_STEP = '1;

    logic [PPS_W-1:0] pcnt;
    logic [PPS_W-1:0] pps_last;
    logic             last_done;

    assign pps_last = steps_pulses(pps_sel) - PPS_W'(1);
    assign load_win = (phase == PH_RAMP) && hs_fall && !last_done;

    always_ff @(posedge clk) begin
        if (rst || !start_req) begin
            phase     <= PH_IDLE;
            step      <= '0;
            pcnt      <= '0;
            last_done <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: phase <= PH_WAIT;
                PH_WAIT: if (hs_gate) phase <= PH_RAMP;
                PH_RAMP: begin
                    if (load_win) begin
                        if (pcnt == pps_last) begin
                            pcnt <= '0;
                            if (step == LAST_STEP) last_done <= 1'b1;
                            else                   step <= step + 1'b1;
                        end else begin
                            pcnt <= pcnt + 1'b1;
                        end
                    end
                    if (last_done && hs_gate) phase <= PH_DONE;
                end
                default: phase <= PH_DONE;
            endcase
        end
    end
endmodule

// File: rtl/lowside_prebias_window.sv
module lowside_prebias_window #(
    parameter int NOM_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             hs_gate,
    input  logic             load,
    input  logic [NOM_W-1:0] limit,
    output logic             open
);
    logic [NOM_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst || clear || hs_gate) remain <= '0;
        else if (load)               remain <= limit;
        else if (remain != '0)       remain <= remain - 1'b1;
    end

    assign open = (remain != '0);
endmodule

// File: rtl/lowside_prebias_ramp.sv
module lowside_prebias_ramp
    import lowside_prebias_ramp_pkg::*;
#(
    parameter int NOM_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_req,
    input  logic             hs_gate,
    input  logic             ls_drive_in,
    input  logic [NOM_W-1:0] nom_on_cycles,
    input  logic [1:0]       pps_sel,
    output logic             ls_gate,
    output logic             ramp_done
);
    phase_t            phase;
    logic [STEP_W-1:0] step;
    logic              load_win;
    logic              hs_fall;
    logic              win_open;
    logic [NOM_W-1:0]  limit;

    assign limit = NOM_W'(quarter_scale(NOM_MAX_W'(nom_on_cycles), step));

    lowside_prebias_hs_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .hs_gate (hs_gate),
        .hs_fall (hs_fall)
    );

    lowside_prebias_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_req),
        .hs_gate   (hs_gate),
        .hs_fall   (hs_fall),
        .pps_sel   (pps_sel),
        .phase     (phase),
        .step      (step),
        .load_win  (load_win)
    );

    lowside_prebias_window #(.NOM_W(NOM_W)) u_win (
        .clk     (clk),
        .rst     (rst),
        .clear   (phase != PH_RAMP),
        .hs_gate (hs_gate),
        .load    (load_win),
        .limit   (limit),
        .open    (win_open)
    );

    always_comb begin
        ls_gate = 1'b0;
        if (start_req) begin
            if (phase == PH_DONE)
                ls_gate = ls_drive_in;
            else if (phase == PH_RAMP)
                ls_gate = win_open && !hs_gate && ls_drive_in;
        end
    end

    assign ramp_done = (phase == PH_DONE);
endmodule

// File: rtl/lowside_prebias_ramp_chk.sv
module lowside_prebias_ramp_chk (
    input logic clk,
    input logic rst,
    input logic start_req,
    input logic hs_gate,
    input logic ls_drive_in,
    input logic ls_gate,
    input logic ramp_done
);
    assert_gate_needs_drive_R6: assert property (@(posedge clk) disable iff (rst)
        ls_gate |-> ls_drive_in);

    assert_no_overlap_R5: assert property (@(posedge clk) disable iff (rst)
        (hs_gate && !ramp_done) |-> !ls_gate);

    assert_idle_gate_low_R8: assert property (@(posedge clk) disable iff (rst)
        !start_req |-> !ls_gate);

    assert_idle_done_low_R8: assert property (@(posedge clk) disable iff (rst)
        !start_req |=> !ramp_done);

    assert_passthru_R7: assert property (@(posedge clk) disable iff (rst)
        (ramp_done && start_req) |-> (ls_gate == ls_drive_in));

    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (ramp_done && start_req) |=> ramp_done);

    assert_done_after_hs_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(ramp_done) |-> $past(hs_gate));
endmodule

bind lowside_prebias_ramp lowside_prebias_ramp_chk u_chk (.*);

// File: tb/lowside_prebias_ramp_bench.sv
module lowside_prebias_ramp_bench;
    localparam int NOM_W = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_req = 1'b0;
    logic             hs_gate = 1'b0;
    logic             ls_drive_in = 1'b0;
    logic [NOM_W-1:0] nom_on_cycles = '0;
    logic [1:0]       pps_sel = 2'b00;
    logic             ls_gate;
    logic             ramp_done;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    lowside_prebias_ramp #(.NOM_W(NOM_W)) u_lowside_prebias_ramp (
        .clk           (clk),
        .rst           (rst),
        .start_req     (start_req),
        .hs_gate       (hs_gate),
        .ls_drive_in   (ls_drive_in),
        .nom_on_cycles (nom_on_cycles),
        .pps_sel       (pps_sel),
        .ls_gate       (ls_gate),
        .ramp_done     (ramp_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int pps_of(input logic [1:0] sel);
        if (sel == 2'b00) return 32;
        if (sel == 2'b01) return 16;
        return 8;
    endfunction

    // One switching period: hs high for hi cycles, then drive high for
    // drv cycles of a lo-cycle low phase; counts gate-high samples.
    task automatic period(input int hi, input int lo, input int drv, output int width);
        hs_gate = 1'b1;
        ls_drive_in = 1'b0;
        repeat (hi) @(negedge clk);
        hs_gate = 1'b0;
        ls_drive_in = 1'b1;
        width = 0;
        for (int i = 1; i <= lo; i++) begin
            @(negedge clk);
            if (ls_gate) width++;
            if (i == drv) ls_drive_in = 1'b0;
        end
    endtask

    task automatic begin_start(input logic [1:0] sel, input int nom);
        start_req = 1'b0;
        hs_gate = 1'b0;
        ls_drive_in = 1'b0;
        @(negedge clk);
        pps_sel = sel;
        nom_on_cycles = NOM_W'(nom);
        start_req = 1'b1;
        @(negedge clk);
    endtask

    // Whole ramp, every pulse measured, then the hand-over pulse.
    task automatic full_ramp(input logic [1:0] sel, input int nom, input string tag);
        int w;
        int lo;
        lo = nom + 4;
        for (int k = 1; k <= 4; k++) begin
            for (int p = 0; p < pps_of(sel); p++) begin
                period(3, lo, lo, w);
                check(w == (k * nom) / 4, {tag, " R2 R3 R4 window width"}, w, (k * nom) / 4);
                check(ramp_done == 1'b0, {tag, " R7 done early"}, ramp_done, 0);
            end
        end
        period(3, lo, lo, w);
        check(ramp_done == 1'b1, {tag, " R7 done after last window"}, ramp_done, 1);
        check(w == lo, {tag, " R7 pass-through width"}, w, lo);
    endtask

    task automatic test_reset;
        ls_drive_in = 1'b1;
        repeat (3) @(negedge clk);
        check(ls_gate == 1'b0, "R9 gate in reset", ls_gate, 0);
        check(ramp_done == 1'b0, "R9 done in reset", ramp_done, 0);
        rst = 1'b0;
        @(negedge clk);
        check(ls_gate == 1'b0, "R9 gate after reset", ls_gate, 0);
        ls_drive_in = 1'b0;
    endtask

    task automatic test_wait_then_ramp8;
        int highs;
        begin_start(2'b10, 20);
        ls_drive_in = 1'b1;
        highs = 0;
        repeat (12) begin
            @(negedge clk);
            if (ls_gate) highs++;
        end
        check(highs == 0, "R1 gate held off before high-side pulse", highs, 0);
        full_ramp(2'b10, 20, "sel10 nom20");
    endtask

    task automatic test_ramp16;
        begin_start(2'b01, 13);
        full_ramp(2'b01, 13, "sel01 nom13");
    endtask

    task automatic test_ramp32;
        begin_start(2'b00, 8);
        full_ramp(2'b00, 8, "sel00 nom8");
    endtask

    task automatic test_ramp_sel11;
        begin_start(2'b11, 4);
        full_ramp(2'b11, 4, "sel11 nom4");
    endtask

    task automatic test_short_edges;
        int w;
        begin_start(2'b10, 16);
        period(2, 10, 2, w);
        check(w == 2, "R6 window cut by drive", w, 2);
        period(2, 3, 3, w);
        check(w == 3, "R5 window cut by high-side rise", w, 3);
        hs_gate = 1'b1;
        ls_drive_in = 1'b1;
        @(negedge clk);
        check(ls_gate == 1'b0, "R5 gate low while high-side on", ls_gate, 0);
        period(2, 10, 10, w);
        check(w == 4, "R2 next window normal", w, 4);
    endtask

    task automatic test_abort_restart;
        int w;
        int highs;
        begin_start(2'b10, 20);
        for (int p = 0; p < 10; p++) period(3, 24, 24, w);
        check(w == 10, "R3 second step reached", w, 10);
        start_req = 1'b0;
        ls_drive_in = 1'b1;
        @(negedge clk);
        check(ls_gate == 1'b0, "R8 gate low after start drop", ls_gate, 0);
        @(negedge clk);
        check(ramp_done == 1'b0, "R8 done low after start drop", ramp_done, 0);
        start_req = 1'b1;
        highs = 0;
        repeat (6) begin
            @(negedge clk);
            if (ls_gate) highs++;
        end
        check(highs == 0, "R8 R1 off again after restart", highs, 0);
        period(3, 24, 24, w);
        check(w == 5, "R8 restart at first quarter", w, 5);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        test_reset();
        test_wait_then_ramp8();
        test_ramp16();
        test_ramp32();
        test_ramp_sel11();
        test_short_edges();
        test_abort_restart();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule